// File: doc/BRIEF.md
# Chip Power State Sequencer

This block steps a chip through five power states: off, deep sleep, sleep, wakeup and on. It also uses one internal step, re-power, on the way back from deep sleep. A power-down pin overrides everything. Request lines from the system move the chip from on into one of the two sleep depths. Wakeup event lines bring it back. Each state drives a fixed set of domain enables: the real-time clock domain, the crystal oscillator, the PLLs and the main power domain. The block also drives a global register clear, and in the on state it gates the high-speed clock to each block.

The wakeup state waits for the crystal to settle before it enters on. By default a counter on the block's clock measures the settling time. Software sets the count through an input. A parameter can select an external settled signal in place of the counter. Sleep keeps the main domain and the real-time clock alive and stops the crystal. Deep sleep keeps only the real-time clock domain, and only the RTC timer can end it. That wakeup first re-powers the main domain for a fixed number of cycles, then enters the normal wakeup state.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it, the state is off (code 0): reg_clr is high and every enable is low.
- R2: pd_n low at a clock edge puts the block in off (code 0) after that edge, whatever the state before.
- R3: In off with pd_n high, the next state is wakeup (code 3).
- R4: Wakeup drives rtc_en, main_pwr_en, xtal_en and pll_en high and hs_clk_en to zero. With the internal counter it lasts settle_lim+1 cycles and then enters on (code 4). A limit of zero gives one cycle.
- R5: In on every domain enable is high, and hs_clk_en equals the value that clk_en_req had before the previous clock edge.
- R6: In on, sleep_req moves to sleep (code 2). Sleep keeps rtc_en and main_pwr_en high, with xtal_en, pll_en and hs_clk_en low.
- R7: In sleep, any set bit of wake_src moves to wakeup. Bit 0 is MAC, bit 1 is host, bit 2 is the RTC timer and bit 3 is the external interrupt.
- R8: In on, deep_req moves to deep sleep (code 1) and wins over sleep_req. In deep sleep only rtc_en is high.
- R9: In deep sleep, wake_src bits 0, 1 and 3 are ignored, and the state stays deep sleep.
- R10: In deep sleep, wake_src bit 2 moves to re-power (code 5). Re-power keeps rtc_en and main_pwr_en high and the crystal and PLLs off. It lasts RAMP_CYC cycles and then enters wakeup.
- R11: reg_clr is high only in off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Power-down pin, low forces off |
| sleep_req | input | 1 | Sleep criteria met |
| deep_req | input | 1 | Deep sleep request |
| wake_src | input | NUM_WAKE | Wakeup events: MAC, host, RTC timer, external |
| xtal_ok_ext | input | 1 | External crystal-settled signal, used when EXT_SETTLE=1 |
| settle_lim | input | CNT_W | Settling count for the internal counter |
| clk_en_req | input | NUM_CLK | Per-block high-speed clock enable register |
| rtc_en | output | 1 | Real-time clock domain enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| main_pwr_en | output | 1 | Main power domain enable |
| hs_clk_en | output | NUM_CLK | High-speed clock gates per block |
| reg_clr | output | 1 | Global register clear |
| state_o | output | 3 | Current state code |

## Verification
The bench builds the block with its defaults: the internal counter for settling (EXT_SETTLE=0), RAMP_CYC=3, an 8-bit count and eight clock gates. Changing settle_lim between visits to wakeup covers both a three-cycle settle and the zero-limit case of a single cycle. The three-cycle re-power gives a window long enough to see the main domain up while the crystal stays off. The eight-bit gate register lets two distinct patterns show the one-cycle latency of the clock gates.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_DEEP  = 3'd1,
    ST_SLEEP = 3'd2,
    ST_WAKE  = 3'd3,
    ST_ON    = 3'd4,
    ST_REPWR = 3'd5
  } pstate_t;

  localparam int WAKE_RTC_BIT = 2;
endpackage

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
  parameter int CNT_W      = 8,
  parameter int RAMP_CYC   = 3,
  parameter bit EXT_SETTLE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [CNT_W-1:0] settle_lim,
  input  logic             xtal_ok_ext,
  output logic             settle_done,
  output logic             ramp_done
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] RAMP_END = CNT_W'(RAMP_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  // Counts cycles spent in the current state; clears on every state change.
  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (EXT_SETTLE) begin : g_ext
      assign settle_done = xtal_ok_ext;
    end else begin : g_cnt
      assign settle_done = (cnt_q >= settle_lim);
    end
  endgenerate

  assign ramp_done = (cnt_q == RAMP_END);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm #(
  parameter int NUM_WAKE = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pd_n,
  input  logic                   sleep_req,
  input  logic                   deep_req,
  input  logic [NUM_WAKE-1:0]    wake_src,
  input  logic                   settle_done,
  input  logic                   ramp_done,
  output pwr_seq_pkg::pstate_t   state_q,
  output pwr_seq_pkg::pstate_t   state_d,
  output logic                   restart
);
  import pwr_seq_pkg::*;

  always_comb begin
    state_d = state_q;
    if (!pd_n) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:   state_d = ST_WAKE;
        ST_WAKE:  if (settle_done) state_d = ST_ON;
        ST_ON:    if (deep_req) state_d = ST_DEEP;
                  else if (sleep_req) state_d = ST_SLEEP;
        ST_SLEEP: if (|wake_src) state_d = ST_WAKE;
        ST_DEEP:  if (wake_src[WAKE_RTC_BIT]) state_d = ST_REPWR;
        ST_REPWR: if (ramp_done) state_d = ST_WAKE;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  assign restart = (state_d != state_q);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_OFF;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/pwr_out_reg.sv
module pwr_out_reg #(
  parameter int NUM_CLK = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pwr_seq_pkg::pstate_t state_d,
  input  logic [NUM_CLK-1:0]   clk_en_req,
  output logic                 rtc_en,
  output logic                 xtal_en,
  output logic                 pll_en,
  output logic                 main_pwr_en,
  output logic [NUM_CLK-1:0]   hs_clk_en,
  output logic                 reg_clr
);
  import pwr_seq_pkg::*;

  logic rtc_n, xtal_n, pll_n, main_n, clr_n;

  always_comb begin
    rtc_n = 1'b0; xtal_n = 1'b0; pll_n = 1'b0; main_n = 1'b0; clr_n = 1'b0;
    case (state_d)
      ST_OFF:   clr_n = 1'b1;
      ST_DEEP:  rtc_n = 1'b1;
      ST_SLEEP, ST_REPWR: begin rtc_n = 1'b1; main_n = 1'b1; end
      ST_WAKE, ST_ON: begin
        rtc_n = 1'b1; main_n = 1'b1; xtal_n = 1'b1; pll_n = 1'b1;
      end
      default:  clr_n = 1'b1;
    endcase
  end

  // Registered from the next state so the outputs line up with the state register.
  always_ff @(posedge clk) begin
    if (rst) begin
      rtc_en <= 1'b0; xtal_en <= 1'b0; pll_en <= 1'b0;
      main_pwr_en <= 1'b0; reg_clr <= 1'b1; hs_clk_en <= '0;
    end else begin
      rtc_en <= rtc_n; xtal_en <= xtal_n; pll_en <= pll_n;
      main_pwr_en <= main_n; reg_clr <= clr_n;
      hs_clk_en <= (state_d == ST_ON) ? clk_en_req : '0;
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int NUM_WAKE   = 4,
  parameter int NUM_CLK    = 8,
  parameter int CNT_W      = 8,
  parameter int RAMP_CYC   = 3,
  parameter bit EXT_SETTLE = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pd_n,
  input  logic                sleep_req,
  input  logic                deep_req,
  input  logic [NUM_WAKE-1:0] wake_src,
  input  logic                xtal_ok_ext,
  input  logic [CNT_W-1:0]    settle_lim,
  input  logic [NUM_CLK-1:0]  clk_en_req,
  output logic                rtc_en,
  output logic                xtal_en,
  output logic                pll_en,
  output logic                main_pwr_en,
  output logic [NUM_CLK-1:0]  hs_clk_en,
  output logic                reg_clr,
  output logic [2:0]          state_o
);
  import pwr_seq_pkg::*;

  pstate_t state_q, state_d;
  logic    restart, settle_done, ramp_done;

  pwr_settle_timer #(
    .CNT_W(CNT_W), .RAMP_CYC(RAMP_CYC), .EXT_SETTLE(EXT_SETTLE)
  ) u_tmr (
    .clk(clk), .rst(rst), .restart(restart), .settle_lim(settle_lim),
    .xtal_ok_ext(xtal_ok_ext), .settle_done(settle_done), .ramp_done(ramp_done)
  );

  pwr_seq_fsm #(.NUM_WAKE(NUM_WAKE)) u_fsm (
    .clk(clk), .rst(rst), .pd_n(pd_n), .sleep_req(sleep_req),
    .deep_req(deep_req), .wake_src(wake_src), .settle_done(settle_done),
    .ramp_done(ramp_done), .state_q(state_q), .state_d(state_d),
    .restart(restart)
  );

  pwr_out_reg #(.NUM_CLK(NUM_CLK)) u_out (
    .clk(clk), .rst(rst), .state_d(state_d), .clk_en_req(clk_en_req),
    .rtc_en(rtc_en), .xtal_en(xtal_en), .pll_en(pll_en),
    .main_pwr_en(main_pwr_en), .hs_clk_en(hs_clk_en), .reg_clr(reg_clr)
  );

  assign state_o = state_q;
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int NUM_WAKE = 4,
  parameter int NUM_CLK  = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                pd_n,
  input logic [NUM_WAKE-1:0] wake_src,
  input logic                rtc_en,
  input logic                xtal_en,
  input logic                pll_en,
  input logic                main_pwr_en,
  input logic [NUM_CLK-1:0]  hs_clk_en,
  input logic                reg_clr,
  input logic [2:0]          state_o
);
  p_pd_forces_off_r2: assert property (@(posedge clk) disable iff (rst)
    !pd_n |=> state_o == 3'd0);

  p_on_after_wake_r4: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd4 && $past(state_o) != 3'd4) |-> $past(state_o) == 3'd3);

  p_on_domains_r5: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'd4 |-> (rtc_en && main_pwr_en && xtal_en && pll_en));

  p_sleep_xtal_off_r6: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'd2 |-> (!xtal_en && !pll_en && rtc_en && hs_clk_en == '0));

  p_deep_only_rtc_r8: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'd1 |-> (rtc_en && !main_pwr_en && !xtal_en && !pll_en));

  p_deep_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd1 && pd_n && !wake_src[2]) |=> state_o == 3'd1);

  p_repwr_xtal_off_r10: assert property (@(posedge clk) disable iff (rst)
    state_o == 3'd5 |-> (main_pwr_en && !xtal_en));

  p_regclr_off_r11: assert property (@(posedge clk) disable iff (rst)
    reg_clr |-> state_o == 3'd0);
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.NUM_WAKE(NUM_WAKE), .NUM_CLK(NUM_CLK)) u_chk (
  .clk(clk), .rst(rst), .pd_n(pd_n), .wake_src(wake_src), .rtc_en(rtc_en),
  .xtal_en(xtal_en), .pll_en(pll_en), .main_pwr_en(main_pwr_en),
  .hs_clk_en(hs_clk_en), .reg_clr(reg_clr), .state_o(state_o)
);

// File: tb/pwr_seq_ctrl_test.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_test;
  localparam int NW = 4;
  localparam int NC = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd_n = 1'b0, sleep_req = 1'b0, deep_req = 1'b0, xtal_ok_ext = 1'b0;
  logic [NW-1:0] wake_src = '0;
  logic [CW-1:0] settle_lim = 8'd2;
  logic [NC-1:0] clk_en_req = 8'hA5;
  logic rtc_en, xtal_en, pll_en, main_pwr_en, reg_clr;
  logic [NC-1:0] hs_clk_en;
  logic [2:0] state_o;

  always #4 clk = ~clk;

  pwr_seq_ctrl uut (
    .clk(clk), .rst(rst), .pd_n(pd_n), .sleep_req(sleep_req),
    .deep_req(deep_req), .wake_src(wake_src), .xtal_ok_ext(xtal_ok_ext),
    .settle_lim(settle_lim), .clk_en_req(clk_en_req), .rtc_en(rtc_en),
    .xtal_en(xtal_en), .pll_en(pll_en), .main_pwr_en(main_pwr_en),
    .hs_clk_en(hs_clk_en), .reg_clr(reg_clr), .state_o(state_o)
  );

  typedef struct {
    logic [2:0]    st;
    logic [NC-1:0] hs;
    string         rq;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // Expected {rtc, main, xtal, pll, reg_clr} per state code, taken from the requirements.
  function automatic logic [4:0] dom_of(input logic [2:0] st);
    case (st)
      3'd0: return 5'b00001;
      3'd1: return 5'b10000;
      3'd2, 3'd5: return 5'b11000;
      3'd3, 3'd4: return 5'b11110;
      default: return 5'b00000;
    endcase
  endfunction

  // Driver side: expectation for the state after the coming edge.
  task automatic tick(input logic [2:0] st, input logic [NC-1:0] hs, input string rq);
    exp_t e;
    @(posedge clk);
    #1;
    e.st = st; e.hs = hs; e.rq = rq;
    exp_q.push_back(e);
  endtask

  // Monitor: compares on the falling edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      logic [4:0] got_d, exp_d;
      e = exp_q.pop_front();
      got_d = {rtc_en, main_pwr_en, xtal_en, pll_en, reg_clr};
      exp_d = dom_of(e.st);
      n_cmp++;
      if (state_o !== e.st || got_d !== exp_d || hs_clk_en !== e.hs) begin
        n_bad++;
        $display("FAIL %s: state=%0d dom=%b hs=%h expected state=%0d dom=%b hs=%h",
                 e.rq, state_o, got_d, hs_clk_en, e.st, exp_d, e.hs);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3'd0, '0, "R1");                 // in reset
    tick(3'd0, '0, "R1");
    rst = 1'b0;
    tick(3'd0, '0, "R2");                 // pd_n still low
    pd_n = 1'b1;
    tick(3'd3, '0, "R3");                 // off -> wakeup
    tick(3'd3, '0, "R4");                 // settle_lim=2: three wakeup cycles
    tick(3'd3, '0, "R4");
    tick(3'd4, 8'hA5, "R4");              // on, gates from register
    clk_en_req = 8'h3C;
    tick(3'd4, 8'h3C, "R5");              // one-cycle latency
    sleep_req = 1'b1;
    tick(3'd2, '0, "R6");
    sleep_req = 1'b0;
    tick(3'd2, '0, "R6");
    wake_src = 4'b0010;                   // host event
    settle_lim = 8'd0;
    tick(3'd3, '0, "R7");
    wake_src = '0;
    tick(3'd4, 8'h3C, "R4");              // zero limit: one wakeup cycle
    deep_req = 1'b1; sleep_req = 1'b1;
    tick(3'd1, '0, "R8");                 // deep wins over sleep
    deep_req = 1'b0; sleep_req = 1'b0;
    wake_src = 4'b1011;                   // no RTC timer bit
    tick(3'd1, '0, "R9");
    tick(3'd1, '0, "R9");
    wake_src = 4'b0100;                   // RTC timer
    tick(3'd5, '0, "R10");
    wake_src = '0;
    tick(3'd5, '0, "R10");
    tick(3'd5, '0, "R10");
    tick(3'd3, '0, "R10");                // after RAMP_CYC=3 cycles
    tick(3'd4, 8'h3C, "R4");
    pd_n = 1'b0;
    tick(3'd0, '0, "R2");                 // forced off from on
    tick(3'd0, '0, "R11");
    pd_n = 1'b1;
    tick(3'd3, '0, "R3");
    pd_n = 1'b0;
    tick(3'd0, '0, "R2");                 // forced off from wakeup
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule